// File: doc/BRIEF.md
# Infrared slow-rate pulse encoder with receive gating

This block sits between a UART transmitter and an infrared transceiver. The UART supplies its serial output bit, a frame-active flag and a 16x baud tick. The block turns every zero bit of a frame, the start bit included, into one short high pulse on the infrared transmit line. One bits and the idle line produce no pulse. The pulse width is chosen at run time: either three sixteenths of a bit period, counted in baud ticks, or a fixed 1.6 microseconds, counted in system clocks. That clock count is derived at elaboration from the clock frequency parameter and rounded up.

On the receive side the block passes the transceiver's receive signal to the decoder through one register. It blanks that signal while the local transmitter is active and for one further bit period afterwards, so the transceiver's echo of the block's own pulses never reaches the decoder. A separate control bit blanks the receive path permanently. A third control bit sets the level of the transceiver's shutdown/mode pin.

Top module: `irsir_sir_codec`

## Requirements
- R1: After reset, `ir_tx_pulse` is 0, `rx_gated` is 0 (the blanked level) and `xcvr_sd` is 1.
- R2: A bit begins on the first `baud_tick16` with `tx_active` high, and again on every 16th tick after that while `tx_active` stays high. `tx_bit` is sampled on that tick. A 0 raises `ir_tx_pulse` at that clock edge and a 1 gives no pulse in that bit.
- R3: With `pw_sel` = 0 at the bit start, the pulse stays high for exactly 3 baud-tick periods. It falls on the clock edge of the third tick after the start tick.
- R4: With `pw_sel` = 1 at the bit start, the pulse stays high for exactly ceil(PULSE_NS × CLK_KHZ / 10^6) clock cycles.
- R5: `pw_sel` is captured at the bit start. Changing it while a pulse is running does not alter that pulse's width.
- R6: While `tx_active` is low, no pulse begins, whatever the value of `tx_bit`.
- R7: With `rx_dis` = 0, `rx_gated` is 0 while `tx_active` is high and until 16 baud ticks have passed after `tx_active` falls. It follows `ir_rx_in` again from the clock edge after the 16th such tick.
- R8: When the receive path is not blanked, `rx_gated` equals `ir_rx_in` delayed by one clock cycle.
- R9: With `rx_dis` = 1, `rx_gated` is 0 from the next clock edge on, regardless of transmit activity or `ir_rx_in`.
- R10: One clock after `xcvr_mode` changes, `xcvr_sd` follows it inverted: 1 for `xcvr_mode` = 0 and 0 for `xcvr_mode` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| tx_active | input | 1 | High while the UART transmits a frame, stop bit included |
| tx_bit | input | 1 | UART serial transmit bit, valid on the tick that begins a bit |
| pw_sel | input | 1 | Pulse width: 0 = 3/16 bit period, 1 = fixed time |
| rx_dis | input | 1 | 1 = blank the receive path permanently |
| xcvr_mode | input | 1 | Transceiver mode control bit |
| ir_rx_in | input | 1 | Receive signal from the transceiver |
| ir_tx_pulse | output | 1 | Infrared transmit pulse, active high |
| rx_gated | output | 1 | Receive signal forwarded to the decoder, 0 when blanked |
| xcvr_sd | output | 1 | Transceiver shutdown/mode pin |

## Verification
The bench keeps 16 ticks per bit and generates a baud tick every 32 clocks. A bit then lasts 512 clocks and the 3/16 pulse lasts 96, so each zero bit's pulse can be counted in full within its own bit window. CLK_KHZ is set to 248000, which puts the fixed-width target at 396.8 cycles. The round-up to 397 then shows up directly in the measured width, which an exact clock value would not reveal. Because the fixed pulse is shorter than the bit, its rising position, its width and a mid-pulse switch of `pw_sel` are all visible within a single bit.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

   typedef enum logic {
      PW_RATIO = 1'b0,
      PW_FIXED = 1'b1
   } pw_sel_e;

   // Whole clock cycles covering a time in ns at a clock in kHz, rounded up.
   function automatic int unsigned fixed_cycles(input int unsigned t_ns,
                                                input int unsigned f_khz);
      logic [63:0] prod;
      prod = 64'(t_ns) * 64'(f_khz) + 64'd999999;
      return 32'(prod / 64'd1000000);
   endfunction

endpackage

// File: rtl/irsir_bit_phase.sv
module irsir_bit_phase #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic tx_active,
   output logic bit_start
);
   localparam int PW = $clog2(OVS);
   localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

   logic [PW-1:0] phase_q;
   logic          in_frame_q;

   // First tick of a frame, or the tick after the last phase of a bit.
   assign bit_start = tick && tx_active && (!in_frame_q || (phase_q == PH_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= '0;
         in_frame_q <= 1'b0;
      end else if (tick) begin
         in_frame_q <= tx_active;
         if (bit_start || !tx_active)
            phase_q <= '0;
         else
            phase_q <= phase_q + PW'(1);
      end
   end
endmodule

// File: rtl/irsir_pulse_gen.sv
module irsir_pulse_gen
   import irsir_pkg::*;
#(
   parameter int          PULSE_TICKS  = 3,
   parameter int unsigned FIX_CYC      = 400,
   parameter bit          ENABLE_FIXED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic bit_start,
   input  logic tx_bit,
   input  logic pw_sel,
   output logic tx_pulse
);
   localparam int RW = $clog2(PULSE_TICKS + 1);
   localparam logic [RW-1:0] RT_LAST = RW'(PULSE_TICKS - 1);

   pw_sel_e       mode_q;
   pw_sel_e       mode_eff;
   logic          active_q;
   logic [RW-1:0] rcnt_q;
   logic          fix_done;
   logic          ratio_done;
   logic          pulse_go;
   logic          pulse_done;

   assign pulse_go   = bit_start && !tx_bit;
   assign ratio_done = tick && (rcnt_q == RT_LAST);
   assign pulse_done = (mode_q == PW_FIXED) ? fix_done : ratio_done;

   generate
      if (ENABLE_FIXED) begin : g_fixed
         localparam int FW = $clog2(FIX_CYC + 1);
         localparam logic [FW-1:0] FX_LAST = FW'(FIX_CYC - 1);
         logic [FW-1:0] fcnt_q;

         assign mode_eff = pw_sel_e'(pw_sel);
         assign fix_done = (fcnt_q == FX_LAST);

         always_ff @(posedge clk) begin
            if (!rst_n)
               fcnt_q <= '0;
            else if (pulse_go)
               fcnt_q <= '0;
            else if (active_q && !fix_done)
               fcnt_q <= fcnt_q + FW'(1);
         end
      end else begin : g_ratio_only
         logic unused_sel;
         assign unused_sel = pw_sel;
         assign mode_eff   = PW_RATIO;
         assign fix_done   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         mode_q   <= PW_RATIO;
         rcnt_q   <= '0;
      end else if (pulse_go) begin
         active_q <= 1'b1;
         mode_q   <= mode_eff;
         rcnt_q   <= '0;
      end else if (active_q) begin
         if (pulse_done)
            active_q <= 1'b0;
         else if (tick && (mode_q == PW_RATIO))
            rcnt_q <= rcnt_q + RW'(1);
      end
   end

   assign tx_pulse = active_q;
endmodule

// File: rtl/irsir_rx_gate.sv
module irsir_rx_gate #(
   parameter int   OVS          = 16,
   parameter logic RX_BLOCK_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic tx_active,
   input  logic rx_dis,
   input  logic rx_in,
   output logic rx_out
);
   localparam int HW = $clog2(OVS + 1);

   logic [HW-1:0] hold_q;
   logic          blocked;

   assign blocked = rx_dis || tx_active || (hold_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         rx_out <= RX_BLOCK_LVL;
      end else begin
         if (tx_active)
            hold_q <= HW'(OVS);
         else if (tick && (hold_q != '0))
            hold_q <= hold_q - HW'(1);
         rx_out <= blocked ? RX_BLOCK_LVL : rx_in;
      end
   end
endmodule

// File: rtl/irsir_sir_codec.sv
module irsir_sir_codec #(
   parameter int          OVS          = 16,
   parameter int          PULSE_TICKS  = 3,
   parameter int unsigned PULSE_NS     = 1600,
   parameter int unsigned CLK_KHZ      = 250000,
   parameter bit          ENABLE_FIXED = 1'b1,
   parameter logic        RX_BLOCK_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick16,
   input  logic tx_active,
   input  logic tx_bit,
   input  logic pw_sel,
   input  logic rx_dis,
   input  logic xcvr_mode,
   input  logic ir_rx_in,
   output logic ir_tx_pulse,
   output logic rx_gated,
   output logic xcvr_sd
);
   localparam int unsigned FIX_CYC = irsir_pkg::fixed_cycles(PULSE_NS, CLK_KHZ);

   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("OVS must be at least 4");
      end
      if (PULSE_TICKS < 1 || PULSE_TICKS >= OVS) begin : g_bad_ticks
         $error("PULSE_TICKS must lie in 1..OVS-1");
      end
      if (ENABLE_FIXED && FIX_CYC < 1) begin : g_bad_fix
         $error("fixed pulse must span at least one clock");
      end
   endgenerate

   logic bit_start;

   irsir_bit_phase #(.OVS(OVS)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick16),
      .tx_active (tx_active),
      .bit_start (bit_start)
   );

   irsir_pulse_gen #(
      .PULSE_TICKS  (PULSE_TICKS),
      .FIX_CYC      (FIX_CYC),
      .ENABLE_FIXED (ENABLE_FIXED)
   ) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick16),
      .bit_start (bit_start),
      .tx_bit    (tx_bit),
      .pw_sel    (pw_sel),
      .tx_pulse  (ir_tx_pulse)
   );

   irsir_rx_gate #(.OVS(OVS), .RX_BLOCK_LVL(RX_BLOCK_LVL)) u_rxg (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick16),
      .tx_active (tx_active),
      .rx_dis    (rx_dis),
      .rx_in     (ir_rx_in),
      .rx_out    (rx_gated)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         xcvr_sd <= 1'b1;
      else
         xcvr_sd <= !xcvr_mode;
   end
endmodule

// File: rtl/irsir_sir_codec_sva.sv
module irsir_sir_codec_sva (
   input logic clk,
   input logic rst_n,
   input logic baud_tick16,
   input logic tx_active,
   input logic tx_bit,
   input logic rx_dis,
   input logic xcvr_mode,
   input logic ir_rx_in,
   input logic ir_tx_pulse,
   input logic rx_gated,
   input logic xcvr_sd
);
   // A pulse only starts on a tick inside a frame with a zero bit.
   assert_pulse_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ir_tx_pulse) |-> $past(baud_tick16 && tx_active && !tx_bit));

   assert_idle_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active && !ir_tx_pulse) |=> !ir_tx_pulse);

   assert_tx_blanks_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> !rx_gated);

   assert_rx_from_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_gated |-> $past(ir_rx_in));

   assert_rx_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dis |=> !rx_gated);

   assert_sd_follows_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (xcvr_sd == !$past(xcvr_mode)));
endmodule

bind irsir_sir_codec irsir_sir_codec_sva u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick16 (baud_tick16),
   .tx_active   (tx_active),
   .tx_bit      (tx_bit),
   .rx_dis      (rx_dis),
   .xcvr_mode   (xcvr_mode),
   .ir_rx_in    (ir_rx_in),
   .ir_tx_pulse (ir_tx_pulse),
   .rx_gated    (rx_gated),
   .xcvr_sd     (xcvr_sd)
);

// File: tb/tb_irsir_sir_codec.sv
module tb_irsir_sir_codec;
   localparam int OVS       = 16;
   localparam int TDIV      = 32;
   localparam int BITCLK    = OVS * TDIV;
   localparam int CLKK      = 248000;
   localparam int EXP_RATIO = 3 * TDIV;
   localparam int EXP_FIX   = int'((64'd1600 * 64'd248000 + 64'd999999) / 64'd1000000);

   // {pw_sel, data byte}
   localparam logic [8:0] VEC [4] = '{9'h055, 9'h1A3, 9'h000, 9'h1FF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick16 = 1'b0, tx_active = 1'b0, tx_bit = 1'b1, pw_sel = 1'b0;
   logic rx_dis = 1'b0, xcvr_mode = 1'b0, ir_rx_in = 1'b0;
   logic ir_tx_pulse, rx_gated, xcvr_sd;
   int   errs = 0, checks = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   irsir_sir_codec #(.CLK_KHZ(CLKK)) dut (
      .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .tx_active(tx_active),
      .tx_bit(tx_bit), .pw_sel(pw_sel), .rx_dis(rx_dis), .xcvr_mode(xcvr_mode),
      .ir_rx_in(ir_rx_in), .ir_tx_pulse(ir_tx_pulse), .rx_gated(rx_gated),
      .xcvr_sd(xcvr_sd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clk1();
      @(posedge clk);
      @(negedge clk);
   endtask

   // One bit of BITCLK clocks; tick in the first clock of each tick period.
   task automatic send_bit(input logic b, input bit flip, output int hi,
                           output int first, output int leak);
      tx_bit = b; hi = 0; first = -1; leak = 0;
      for (int k = 0; k < BITCLK; k++) begin
         baud_tick16 = (k % TDIV == 0);
         if (flip && k == 2) pw_sel = !pw_sel;
         clk1();
         if (ir_tx_pulse) begin
            hi++;
            if (first < 0) first = k;
         end
         if (rx_gated) leak++;
      end
      baud_tick16 = 1'b0;
   endtask

   task automatic check_bit(input logic b, input logic sel, input int hi, input int first,
                            input int leak);
      int exp;
      exp = b ? 0 : (sel ? EXP_FIX : EXP_RATIO);
      if (b) chk(hi == 0, "R2 one bit gives no pulse", hi, 0);
      else if (sel) chk(hi == exp, "R4 fixed pulse width", hi, exp);
      else chk(hi == exp, "R3 ratio pulse width", hi, exp);
      if (!b) chk(first == 0, "R2 pulse starts at bit tick", first, 0);
      chk(leak == 0, "R7 rx blanked during frame", leak, 0);
   endtask

   // After tx_active falls: blanked through the 16th tick, open one edge later.
   task automatic guard_tail();
      tx_active = 1'b0; tx_bit = 1'b1;
      for (int k = 0; k < BITCLK + 4; k++) begin
         baud_tick16 = (k % TDIV == 0);
         clk1();
         if (k == 15 * TDIV) chk(rx_gated == 1'b0, "R7 still blanked at 16th tick", rx_gated, 0);
         if (k == 15 * TDIV + 1) chk(rx_gated == 1'b1, "R7 reopened after 16th tick", rx_gated, 1);
      end
      baud_tick16 = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] d, input logic sel);
      int hi, first, leak;
      logic b;
      pw_sel = sel; ir_rx_in = 1'b1; tx_active = 1'b1;
      for (int i = 0; i < 10; i++) begin
         b = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : d[i-1];
         send_bit(b, 1'b0, hi, first, leak);
         check_bit(b, sel, hi, first, leak);
      end
      guard_tail();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int hi, first, leak, cnt;
      @(negedge clk);
      repeat (3) clk1();
      // R1 reset state
      chk(ir_tx_pulse == 1'b0, "R1 pulse low in reset", ir_tx_pulse, 0);
      chk(rx_gated == 1'b0, "R1 rx blanked in reset", rx_gated, 0);
      chk(xcvr_sd == 1'b1, "R1 sd high in reset", xcvr_sd, 1);
      rst_n = 1'b1;
      clk1();
      chk(ir_tx_pulse == 1'b0 && xcvr_sd == 1'b1, "R1 state after release", xcvr_sd, 1);

      // R10 mode pin
      xcvr_mode = 1'b1; clk1();
      chk(xcvr_sd == 1'b0, "R10 mode 1 drives sd low", xcvr_sd, 0);
      xcvr_mode = 1'b0; clk1();
      chk(xcvr_sd == 1'b1, "R10 mode 0 drives sd high", xcvr_sd, 1);

      // R9 permanent disable, then R8 pass-through
      rx_dis = 1'b1; ir_rx_in = 1'b1;
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         baud_tick16 = (k % TDIV == 0); clk1();
         if (rx_gated) cnt++;
      end
      baud_tick16 = 1'b0;
      chk(cnt == 0, "R9 rx disabled while idle", cnt, 0);
      rx_dis = 1'b0; clk1();
      chk(rx_gated == 1'b1, "R8 rx passes when enabled", rx_gated, 1);
      ir_rx_in = 1'b0; clk1();
      chk(rx_gated == 1'b0, "R8 rx follows low", rx_gated, 0);
      ir_rx_in = 1'b1; clk1();
      chk(rx_gated == 1'b1, "R8 rx follows high", rx_gated, 1);

      // R6 zero data while idle makes no pulse
      tx_bit = 1'b0; cnt = 0;
      for (int k = 0; k < 4 * TDIV; k++) begin
         baud_tick16 = (k % TDIV == 0); clk1();
         if (ir_tx_pulse) cnt++;
      end
      baud_tick16 = 1'b0;
      chk(cnt == 0, "R6 no pulse while idle", cnt, 0);

      // Table of frames
      foreach (VEC[i]) send_frame(VEC[i][7:0], VEC[i][8]);

      // R5 pw_sel captured at bit start; R9 overrides during a frame
      pw_sel = 1'b0; tx_active = 1'b1;
      send_bit(1'b0, 1'b1, hi, first, leak);
      chk(hi == EXP_RATIO, "R5 ratio width kept after switch", hi, EXP_RATIO);
      send_bit(1'b0, 1'b1, hi, first, leak);
      chk(hi == EXP_FIX, "R5 fixed width kept after switch", hi, EXP_FIX);
      rx_dis = 1'b1;
      send_bit(1'b1, 1'b0, hi, first, leak);
      chk(leak == 0, "R9 rx disabled during frame", leak, 0);
      rx_dis = 1'b0;
      guard_tail();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule